// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Control Model

This block is a synthesizable, clock-based model of a byte-wide one-time-programmable memory and the logic that decides its operating mode. It watches three active-low strobes: chip select, output gate and program strobe. It also watches two digital flags. One stands in for the raised programming supply and the other for the raised voltage on the identify address line. From these inputs it decides whether the part sits in standby, is waiting for its access time, is driving data, or is burning a byte. The bidirectional data pins are split into a data-in bus, a data-out bus and an output-enable.

Every cell starts erased at all ones. A program pulse can only clear bits, because the stored byte is ANDed with the written byte. The read path returns one of three things: array contents (a normal read, or a verify read with the supply flag still raised), a fixed identifier byte with odd parity when the identify flag is set, or all ones with an error flag when the identify request is malformed. Access time from chip select and from the output gate are counted in clock cycles. A system uses chip select to pick one device. The output gate is shared as a read strobe.

The mode FSM has four states. `ST_STANDBY` means chip select is high. `ST_WAIT` means the device is selected but not yet driving. `ST_READ` means data is driven. `ST_PROGRAM` means a write is in progress. From any state the transitions are:
- to standby when chip select is high;
- to program when a program request is present;
- to read when both access timers are satisfied and the output gate is low;
- otherwise to wait.

A write fires only on the entry transition into `ST_PROGRAM`.

Top module: `otp_eprom_model`

## Requirements
- R1: After reset, `dout_en`, `id_err` and `dout` are 0, and every cell reads 0xFF.
- R2: `dout_en` is high only in the cycle after an edge that sampled both `ce_n` and `oe_n` low, and `dout` is 0 whenever `dout_en` is low.
- R3: An edge that samples `ce_n` high puts the block in standby, and `dout_en` is low after it, whatever `oe_n` is.
- R4: The address timer counts consecutive edges with `ce_n` low and with `addr` and `a9_hv` unchanged from the previous edge, saturating at T_ACC. The gate timer counts consecutive edges with `oe_n` low, saturating at T_OE. `dout_en` rises after the edge at which both timers are full. With the address held, lowering `ce_n` and `oe_n` together gives data after T_ACC edges. Lowering `oe_n` late gives data after T_OE edges.
- R5: An edge that samples a changed `addr` or `a9_hv` resets the address timer to zero. `dout_en` drops after that edge and returns T_ACC+1 edges after the change.
- R6: A program request is `ce_n` low, `vpp_hi` high and `pgm_n` low. On the first edge of each request the addressed cell becomes old AND `din`. Later edges of the same request write nothing.
- R7: With `ce_n` high, or with `vpp_hi` low, no cell changes.
- R8: With `vpp_hi` high, `pgm_n` high and `ce_n`/`oe_n` low, the array byte is read back (verify).
- R9: With `a9_hv` set and no program request, the read returns an identifier instead of the array. `addr[0]`=0 gives the maker byte (default 0xC2) and `addr[0]`=1 gives the device byte (default 0x0E).
- R10: Each identifier byte has odd parity, and bit 7 is the parity bit.
- R11: In identify mode, if any of `addr[ADDR_W-1:1]` is nonzero, the read returns 0xFF with `id_err` high. Otherwise `id_err` is low.
- R12: During a program request `dout_en` is low, and a program request takes precedence over identify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to burn |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | Identify line at high voltage |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Data pins driven |
| id_err | output | 1 | Malformed identify request |

## Verification
Two collisions get the most attention.

The first is a program request that arrives while the identify flag is set and the output gate is low. The device could either burn the byte or present an identifier. The bench provokes this and expects the write to land and the outputs to stay off. A later plain read then confirms the byte.

The second is chip select rising while the output gate stays low. The block must then fall to standby rather than keep driving.

In both cases a behavioural reference model, run every cycle, judges enable, data and error. Directed checks add exact edge counts for the access timers.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_STANDBY,
        ST_WAIT,
        ST_READ,
        ST_PROGRAM
    } otp_state_e;

    // Prefix seven payload bits with a bit that makes the byte's parity odd.
    function automatic logic [BYTE_W-1:0] odd_byte(input logic [BYTE_W-2:0] payload);
        return {~(^payload), payload};
    endfunction

endpackage

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
    parameter int ADDR_W = 8,
    parameter int T_ACC  = 4,
    parameter int T_OE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              id_hv,
    output logic              ready
);
    localparam int ACC_W = $clog2(T_ACC + 1);
    localparam int OE_W  = $clog2(T_OE + 1);
    localparam logic [ACC_W-1:0] ACC_FULL = ACC_W'(T_ACC);
    localparam logic [OE_W-1:0]  OE_FULL  = OE_W'(T_OE);

    logic [ACC_W-1:0]  acc_q, acc_nx;
    logic [OE_W-1:0]   oe_q, oe_nx;
    logic [ADDR_W-1:0] addr_q;
    logic              hv_q;
    logic              moved;

    always_comb begin
        moved = (addr != addr_q) || (id_hv != hv_q);
        if (ce_n || moved)          acc_nx = '0;
        else if (acc_q == ACC_FULL) acc_nx = acc_q;
        else                        acc_nx = acc_q + 1'b1;
        if (oe_n)                   oe_nx = '0;
        else if (oe_q == OE_FULL)   oe_nx = oe_q;
        else                        oe_nx = oe_q + 1'b1;
        ready = !ce_n && !oe_n && (acc_nx == ACC_FULL) && (oe_nx == OE_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            oe_q   <= '0;
            addr_q <= '0;
            hv_q   <= 1'b0;
        end else begin
            acc_q  <= acc_nx;
            oe_q   <= oe_nx;
            addr_q <= addr;
            hv_q   <= id_hv;
        end
    end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[addr] <= cells[addr] & wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
    parameter logic [6:0] MAKER_ID  = 7'h42,
    parameter logic [6:0] DEVICE_ID = 7'h0E
) (
    input  logic       sel,
    output logic [7:0] id_byte
);
    import otp_pkg::*;

    localparam logic [7:0] MAKER_BYTE  = odd_byte(MAKER_ID);
    localparam logic [7:0] DEVICE_BYTE = odd_byte(DEVICE_ID);

    assign id_byte = sel ? DEVICE_BYTE : MAKER_BYTE;
endmodule

// File: rtl/otp_eprom_model.sv
module otp_eprom_model #(
    parameter int         ADDR_W    = 8,
    parameter int         T_ACC     = 4,
    parameter int         T_OE      = 2,
    parameter logic [6:0] MAKER_ID  = 7'h42,
    parameter logic [6:0] DEVICE_ID = 7'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              id_err
);
    import otp_pkg::*;

    otp_state_e  state_q, state_nx;
    logic        ready, prog_req, write_pulse, id_bad;
    logic [7:0]  arr_rdata, id_byte, rd_byte;
    logic [7:0]  dout_q;
    logic        err_q;

    otp_access_timer #(.ADDR_W(ADDR_W), .T_ACC(T_ACC), .T_OE(T_OE)) u_timer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .addr(addr), .id_hv(a9_hv), .ready(ready)
    );

    otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .wr_en(write_pulse),
        .addr(addr), .wdata(din), .rdata(arr_rdata)
    );

    otp_id_rom #(.MAKER_ID(MAKER_ID), .DEVICE_ID(DEVICE_ID)) u_id (
        .sel(addr[0]), .id_byte(id_byte)
    );

    assign prog_req = !ce_n && vpp_hi && !pgm_n;
    assign id_bad   = |addr[ADDR_W-1:1];

    always_comb begin
        if (ce_n)          state_nx = ST_STANDBY;
        else if (prog_req) state_nx = ST_PROGRAM;
        else if (ready)    state_nx = ST_READ;
        else               state_nx = ST_WAIT;

        unique case (state_q)
            ST_PROGRAM:                   write_pulse = 1'b0;
            ST_STANDBY, ST_WAIT, ST_READ: write_pulse = (state_nx == ST_PROGRAM);
            default:                      write_pulse = 1'b0;
        endcase

        if (!a9_hv)      rd_byte = arr_rdata;
        else if (id_bad) rd_byte = 8'hFF;
        else             rd_byte = id_byte;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            err_q  <= 1'b0;
        end else if (state_nx == ST_READ) begin
            dout_q <= rd_byte;
            err_q  <= a9_hv && id_bad;
        end else begin
            dout_q <= '0;
            err_q  <= 1'b0;
        end
    end

    assign dout    = dout_q;
    assign dout_en = (state_q == ST_READ);
    assign id_err  = err_q;
endmodule

// File: rtl/otp_eprom_sva.sv
module otp_eprom_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       pgm_n,
    input logic       vpp_hi,
    input logic       a9_hv,
    input logic [7:0] dout,
    input logic       dout_en,
    input logic       id_err
);
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en);                                              // R3
    AST_GATE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dout_en);                                              // R2
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00));                                   // R2
    AST_PROGRAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_hi && !pgm_n) |=> !dout_en);                       // R12
    AST_ID_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |-> (dout_en && dout == 8'hFF));                          // R11
    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && !id_err && $past(a9_hv)) |-> (^dout == 1'b1));       // R10
endmodule

bind otp_eprom_model otp_eprom_sva u_sva (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .dout(dout), .dout_en(dout_en), .id_err(id_err)
);

// File: tb/otp_eprom_model_tb.sv
module otp_eprom_model_tb;
    localparam int ADDR_W = 8;
    localparam int T_ACC  = 4;
    localparam int T_OE   = 2;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] din = '0;
    logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
    logic [7:0] dout;
    logic dout_en, id_err;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    otp_eprom_model #(.ADDR_W(ADDR_W), .T_ACC(T_ACC), .T_OE(T_OE)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
        .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv),
        .dout(dout), .dout_en(dout_en), .id_err(id_err)
    );

    // Behavioural reference
    int         m_acc, m_oe, m_paddr;
    bit         m_pa9, m_prog_prev, m_en, m_err;
    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_dout;
    string      m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_oe = 0; m_paddr = 0; m_pa9 = 0; m_prog_prev = 0;
            m_en = 0; m_err = 0; m_dout = 0; m_tag = "R1";
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
        end else begin
            bit moved, prog;
            moved = (int'(addr) != m_paddr) || (a9_hv != m_pa9);
            if (ce_n || moved) m_acc = 0; else if (m_acc < T_ACC) m_acc++;
            if (oe_n) m_oe = 0; else if (m_oe < T_OE) m_oe++;
            prog = !ce_n && vpp_hi && !pgm_n;
            if (prog && !m_prog_prev) m_mem[addr] = m_mem[addr] & din;
            m_en = !ce_n && !prog && !oe_n && m_acc == T_ACC && m_oe == T_OE;
            m_err = 0; m_dout = 0;
            if (m_en) begin
                if (!a9_hv) m_dout = m_mem[addr];
                else if ((addr >> 1) != 0) begin m_dout = 8'hFF; m_err = 1; end
                else m_dout = addr[0] ? 8'h0E : 8'hC2;
            end
            m_tag = prog ? "R12" : ce_n ? "R3" : a9_hv ? "R9" : "R2";
            m_prog_prev = prog; m_paddr = int'(addr); m_pa9 = a9_hv;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (dout_en !== m_en || dout !== m_dout || id_err !== m_err) begin
                errors++;
                $display("FAIL %s cycle model: en=%0b dout=%02h err=%0b expected en=%0b dout=%02h err=%0b",
                         m_tag, dout_en, dout, id_err, m_en, m_dout, m_err);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_en(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!dout_en && n < 40);
    endtask

    task automatic read_at(input int a, input bit hv);
        int n;
        ce_n = 1; oe_n = 1; cyc(1);
        addr = ADDR_W'(a); a9_hv = hv; cyc(1);
        ce_n = 0; oe_n = 0; wait_en(n);
    endtask

    task automatic burn(input int a, input logic [7:0] d);
        ce_n = 1; oe_n = 1; vpp_hi = 1; pgm_n = 0; addr = ADDR_W'(a); din = d; cyc(1);
        ce_n = 0; cyc(1);
        din = 8'h00; cyc(1);            // same request: must not write again (R6)
        ce_n = 1; cyc(1);
    endtask

    initial begin
        int n;
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        chk("R1", dout_en, 0); chk("R1", id_err, 0); chk("R1", dout, 0);

        addr = 8'd5; cyc(2);
        ce_n = 0; oe_n = 0; wait_en(n);
        chk("R4", n, T_ACC);
        chk("R1", dout, 8'hFF);

        ce_n = 1; cyc(1);
        chk("R3", dout_en, 0);

        ce_n = 0; oe_n = 1; cyc(T_ACC + 2);
        chk("R2", dout_en, 0);
        oe_n = 0; wait_en(n);
        chk("R4", n, T_OE);

        addr = 8'd6; cyc(1);
        chk("R5", dout_en, 0);
        wait_en(n);
        chk("R5", n + 1, T_ACC + 1);

        burn(3, 8'hA5);
        chk("R12", dout_en, 0);

        vpp_hi = 1; pgm_n = 0; addr = 8'd4; din = 8'h00; ce_n = 1; cyc(3);   // inhibited by CE
        vpp_hi = 0; ce_n = 0; cyc(2);                                        // no supply
        ce_n = 1; pgm_n = 1; vpp_hi = 1; cyc(1);

        read_at(3, 0);
        chk("R8", dout, 8'hA5); chk("R6", dout, 8'hA5);
        read_at(4, 0);
        chk("R7", dout, 8'hFF);

        burn(3, 8'h0F);
        pgm_n = 1;
        read_at(3, 0);
        chk("R6", dout, 8'h05);
        vpp_hi = 0;

        read_at(0, 1);
        chk("R9", dout, 8'hC2); chk("R10", ^dout, 1); chk("R11", id_err, 0);
        read_at(1, 1);
        chk("R9", dout, 8'h0E); chk("R10", ^dout, 1);
        read_at(2, 1);
        chk("R11", dout, 8'hFF); chk("R11", id_err, 1);
        addr = 8'd0; cyc(1);
        chk("R5", dout_en, 0);
        wait_en(n);
        chk("R11", id_err, 0);

        // Program request while identify is raised and the gate is low
        ce_n = 1; oe_n = 0; a9_hv = 1; vpp_hi = 1; pgm_n = 0; addr = 8'd7; din = 8'h3C; cyc(1);
        ce_n = 0; cyc(2);
        chk("R12", dout_en, 0);
        ce_n = 1; cyc(1);
        a9_hv = 0; vpp_hi = 0; pgm_n = 1;
        read_at(7, 0);
        chk("R6", dout, 8'h3C);

        ce_n = 1; oe_n = 0; cyc(1);
        chk("R3", dout_en, 0);
        cyc(2);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule